// File: doc/BRIEF.md
# Pipelined Bus Transaction Phase Tracker

This block follows every transaction on a pipelined memory bus from its request until it retires. A transaction runs through five phases in a fixed order: request, error report, snoop, response and data. Each phase drives its own group of bus signals, so in any cycle each phase can belong to a different transaction. Up to eight transactions are outstanding at once. A transaction that finds the next phase still held by an older one waits without holding anything. A delay caused by a long response or data phase therefore pushes back every transaction behind it.

A master presents a request together with the lengths of its response and data phases. The tracker gives the request the next tag and then reports, cycle by cycle, which tag holds each phase. The data-busy indication covers the whole data phase. When a transaction's data phase ends, the tracker sends a one-cycle retirement pulse. A transaction whose error-report cycle sees an error is dropped from the remaining phases but still retires in its turn, and the pulse flags the abort. Bus arbitration and the data itself are handled elsewhere.

Top module: `bus_phase_tracker`

## Requirements
- R1: At most eight transactions are in flight. `req_ready` is low exactly while eight are in flight. A request presented while `req_ready` is low is not taken: it consumes no tag and never retires.
- R2: Tags are handed out in issue order. The first tag after reset is 0 and tags count up modulo 8. `req_tag` shows the tag the next accepted request will receive.
- R3: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high, and it holds the request phase in the cycle that follows. If its phases are single-cycle and nothing older stands in the way, it holds error report, snoop, response and data in the next four cycles, one per cycle.
- R4: Bit i of `own_vld` is high while phase i is held, and `own_tag[3i+2:3i]` carries the holder's tag. The phase numbers are 0 request, 1 error report, 2 snoop, 3 response, 4 data. Each phase has at most one holder.
- R5: A response phase lasts `req_rsp_len`+1 cycles. A later transaction that has finished its snoop phase waits without holding snoop, and it enters response in the cycle after the older response ends.
- R6: A data phase lasts `req_dat_len`+1 cycles, and `data_busy` is high exactly while the data phase is held. A later transaction waits for it and enters data in the cycle after `data_busy` would otherwise drop.
- R7: A stall delays every transaction issued back-to-back behind it by the same number of cycles, so the gap persists.
- R8: `done_vld` pulses for one cycle in the cycle after a transaction's last data cycle, with its tag on `done_tag`. Retirements follow issue order.
- R9: If `err_in` is high in a transaction's error-report cycle, that transaction never holds snoop, response or data. It retires in order with `done_err` = 1. With nothing older outstanding, the pulse comes in the third cycle after its error-report cycle.
- R10: `err_in` has no effect in a cycle when no transaction holds the error-report phase.
- R11: During and right after reset, `own_vld` is 0, `req_ready` is 1, `req_tag` is 0, and `done_vld` and `data_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | New request presented |
| req_rsp_len | input | 2 | Response phase length minus one |
| req_dat_len | input | 2 | Data phase length minus one |
| req_ready | output | 1 | Tracker can take a request |
| req_tag | output | 3 | Tag for the next accepted request |
| err_in | input | 1 | Error reported in the current error-report cycle |
| own_vld | output | 5 | Per-phase held flags |
| own_tag | output | 15 | Per-phase holder tags, 3 bits per phase |
| data_busy | output | 1 | Data phase is held |
| done_vld | output | 1 | Retirement pulse |
| done_tag | output | 3 | Tag being retired |
| done_err | output | 1 | Retired transaction was aborted |

## Verification
The bench stalls the pipeline with a three-cycle response and, separately, with a four-cycle data phase. It then checks that waiting transactions let go of snoop and response. A design that kept a waiting transaction in its old phase would show the wrong holder or a blocked follower. It also checks that the retirement pulses are shifted by the full stall, which a design that quietly closes gaps would fail. The bench aborts one transaction through a mid-stream error and checks that no phase is held in its name and that its follower keeps pace. It also raises an error in an idle cycle, fills all eight slots, and presents a request while full. A design that let that request through would retire nine transactions, and a tag that wrapped wrongly would break the retirement order.

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker #(
  parameter  int SLOTS = 8,
  parameter  int LW    = 2,
  localparam int TW    = $clog2(SLOTS),
  localparam int NPH   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LW-1:0]     req_rsp_len,
  input  logic [LW-1:0]     req_dat_len,
  output logic              req_ready,
  output logic [TW-1:0]     req_tag,
  input  logic              err_in,
  output logic [NPH-1:0]    own_vld,
  output logic [NPH*TW-1:0] own_tag,
  output logic              data_busy,
  output logic              done_vld,
  output logic [TW-1:0]     done_tag,
  output logic              done_err
);
  localparam int FW   = $clog2(SLOTS + 1);
  localparam int PREQ = 0;
  localparam int PERR = 1;
  localparam int PSNP = 2;
  localparam int PRSP = 3;
  localparam int PDAT = 4;

  logic [NPH-1:0][TW:0]     ptr;
  logic [NPH-1:0]           ov;
  logic [NPH-1:0][TW-1:0]   ot;
  logic [NPH-1:0][LW-1:0]   cnt;
  logic [SLOTS-1:0][LW-1:0] rlen;
  logic [SLOTS-1:0][LW-1:0] dlen;
  logic [SLOTS-1:0]         abt_q;
  logic [FW-1:0]            inflight;

  logic [NPH-1:0]           fin;
  logic [NPH-1:0]           go;
  logic [NPH-1:0]           skip;
  logic [NPH-1:0][TW-1:0]   cand;
  logic [NPH-1:0][LW-1:0]   ld;
  logic                     accept;
  logic                     retire;

  assign req_ready = inflight < FW'(SLOTS);
  assign accept    = req_valid && req_ready;
  assign req_tag   = ptr[PREQ][TW-1:0];
  assign own_vld   = ov;
  assign own_tag   = ot;
  assign data_busy = ov[PDAT];

  // cand[p]: oldest tag not yet through phase p
  always_comb begin
    fin  = '0;
    go   = '0;
    skip = '0;
    cand = '0;
    ld   = '0;
    for (int p = 0; p < NPH; p++) begin
      fin[p]  = ov[p] && (cnt[p] == '0);
      cand[p] = ptr[p][TW-1:0];
    end
    for (int p = 1; p < NPH; p++) begin
      skip[p] = (p >= PSNP) &&
                (abt_q[cand[p]] ||
                 (p == PSNP && ov[PERR] && ot[PERR] == cand[p] && err_in));
      go[p]   = (ptr[p] != ptr[p-1]) &&
                !(ov[p-1] && ot[p-1] == cand[p] && !fin[p-1]) &&
                (skip[p] ? !ov[p] : (!ov[p] || fin[p]));
    end
    ld[PRSP] = rlen[cand[PRSP]];
    ld[PDAT] = dlen[cand[PDAT]];
  end

  assign retire = fin[PDAT] || (go[PDAT] && skip[PDAT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      ov       <= '0;
      ot       <= '0;
      cnt      <= '0;
      rlen     <= '0;
      dlen     <= '0;
      abt_q    <= '0;
      inflight <= '0;
      done_vld <= 1'b0;
      done_tag <= '0;
      done_err <= 1'b0;
    end else begin
      ov[PREQ]  <= accept;
      cnt[PREQ] <= '0;
      if (accept) begin
        ot[PREQ]              <= cand[PREQ];
        ptr[PREQ]             <= ptr[PREQ] + 1'b1;
        rlen[cand[PREQ]]      <= req_rsp_len;
        dlen[cand[PREQ]]      <= req_dat_len;
        abt_q[cand[PREQ]]     <= 1'b0;
      end
      if (fin[PERR] && err_in)
        abt_q[ot[PERR]] <= 1'b1;
      for (int p = 1; p < NPH; p++) begin
        if (go[p])
          ptr[p] <= ptr[p] + 1'b1;
        if (go[p] && !skip[p]) begin
          ov[p]  <= 1'b1;
          ot[p]  <= cand[p];
          cnt[p] <= ld[p];
        end else if (fin[p]) begin
          ov[p] <= 1'b0;
        end else if (ov[p]) begin
          cnt[p] <= cnt[p] - 1'b1;
        end
      end
      inflight <= inflight + FW'(accept) - FW'(retire);
      done_vld <= retire;
      done_tag <= fin[PDAT] ? ot[PDAT] : cand[PDAT];
      done_err <= !fin[PDAT];
    end
  end

  logic [TW-1:0] last_done;
  logic          seen_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_done <= '0;
      seen_done <= 1'b0;
    end else if (done_vld) begin
      last_done <= done_tag;
      seen_done <= 1'b1;
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= FW'(SLOTS));
  a_r1_refused_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_tag));
  a_r3_err_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ov[PERR] |-> $past(ov[PREQ]) && ot[PERR] == $past(ot[PREQ]));
  a_r4_rsp_dat_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    ov[PRSP] && ov[PDAT] |-> ot[PRSP] != ot[PDAT]);
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    ov[PDAT] && cnt[PDAT] != '0 |=> ov[PDAT] && $stable(ot[PDAT]));
  a_r8_retire_order: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && seen_done |-> done_tag == last_done + 1'b1);
  a_r9_abort_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    ov[PDAT] |-> !abt_q[ot[PDAT]]);
endmodule

// File: tb/tb_bus_phase_tracker.sv
module tb_bus_phase_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_rsp_len = '0;
  logic [1:0]   req_dat_len = '0;
  logic         req_ready;
  logic [TW-1:0] req_tag;
  logic         err_in = 1'b0;
  logic [4:0]   own_vld;
  logic [14:0]  own_tag;
  logic         data_busy;
  logic         done_vld;
  logic [TW-1:0] done_tag;
  logic         done_err;

  int n_chk = 0;
  int n_bad = 0;

  bus_phase_tracker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_rsp_len(req_rsp_len), .req_dat_len(req_dat_len),
    .req_ready(req_ready), .req_tag(req_tag), .err_in(err_in),
    .own_vld(own_vld), .own_tag(own_tag), .data_busy(data_busy),
    .done_vld(done_vld), .done_tag(done_tag), .done_err(done_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got 1 expected 0");
    report();
    $finish;
  end

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic ph(string rq, int p, int t);
    chk(rq, $sformatf("tag of phase %0d", p), int'(own_tag[p*TW +: TW]), t);
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic drv(bit v, int r, int d, bit e);
    req_valid   = v;
    req_rsp_len = 2'(r);
    req_dat_len = 2'(d);
    err_in      = e;
  endtask

  task automatic t_reset();
    drv(0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) nx();
    chk("R11", "own_vld in reset", int'(own_vld), 0);
    rst_n = 1'b1;
    nx();
    chk("R11", "own_vld", int'(own_vld), 0);
    chk("R11", "req_ready", int'(req_ready), 1);
    chk("R11", "req_tag", int'(req_tag), 0);
    chk("R11", "done_vld", int'(done_vld), 0);
    chk("R11", "data_busy", int'(data_busy), 0);
  endtask

  task automatic t_single();
    nx(); drv(1, 0, 0, 0);
    nx(); drv(0, 0, 0, 0);
    chk("R3", "own_vld req", int'(own_vld), 5'b00001); ph("R4", 0, 0);
    chk("R2", "req_tag after first", int'(req_tag), 1);
    nx(); chk("R3", "own_vld err", int'(own_vld), 5'b00010); ph("R4", 1, 0);
    nx(); chk("R3", "own_vld snp", int'(own_vld), 5'b00100); ph("R4", 2, 0);
    nx(); chk("R3", "own_vld rsp", int'(own_vld), 5'b01000); ph("R4", 3, 0);
    nx(); chk("R3", "own_vld dat", int'(own_vld), 5'b10000); ph("R4", 4, 0);
    chk("R6", "data_busy", int'(data_busy), 1);
    nx(); chk("R8", "done_vld", int'(done_vld), 1);
    chk("R8", "done_tag", int'(done_tag), 0);
    chk("R8", "done_err", int'(done_err), 0);
    chk("R6", "data_busy after", int'(data_busy), 0);
    nx(); chk("R8", "done one cycle", int'(done_vld), 0);
  endtask

  task automatic t_pipe();
    nx(); drv(1, 0, 0, 0);
    nx(); nx();
    nx(); drv(0, 0, 0, 0);
    chk("R4", "three phases", int'(own_vld), 5'b00111);
    ph("R4", 0, 3); ph("R4", 1, 2); ph("R4", 2, 1);
    nx(); chk("R3", "shifted", int'(own_vld), 5'b01110);
    ph("R3", 3, 1); ph("R3", 2, 2); ph("R3", 1, 3);
    nx(); chk("R3", "shifted again", int'(own_vld), 5'b11100);
    ph("R3", 4, 1); ph("R3", 3, 2); ph("R3", 2, 3);
    for (int i = 1; i <= 3; i++) begin
      nx();
      chk("R8", "pipe done_vld", int'(done_vld), 1);
      chk("R8", "pipe done_tag", int'(done_tag), i);
    end
    nx();
  endtask

  task automatic t_rsp_stall();
    nx(); drv(1, 2, 0, 0);
    nx(); drv(1, 0, 0, 0);
    nx();
    nx(); drv(0, 0, 0, 0);
    nx(); chk("R5", "n4 own", int'(own_vld), 5'b01110);
    nx(); chk("R5", "n5 own", int'(own_vld), 5'b01100);
    ph("R5", 3, 4); ph("R5", 2, 6);
    nx(); chk("R5", "waiting frees snoop", int'(own_vld), 5'b01000);
    ph("R5", 3, 4);
    nx(); chk("R5", "n7 own", int'(own_vld), 5'b11000);
    ph("R5", 4, 4); ph("R5", 3, 5);
    nx(); chk("R8", "done 4", int'(done_vld), 1); chk("R8", "tag 4", int'(done_tag), 4);
    ph("R7", 4, 5); ph("R7", 3, 6);
    nx(); chk("R7", "done 5", int'(done_vld), 1); chk("R7", "tag 5", int'(done_tag), 5);
    chk("R7", "n9 own", int'(own_vld), 5'b10000); ph("R7", 4, 6);
    nx(); chk("R7", "done 6 late", int'(done_vld), 1); chk("R7", "tag 6", int'(done_tag), 6);
    nx();
  endtask

  task automatic t_dat_stall();
    nx(); drv(1, 0, 3, 0);
    nx(); drv(1, 0, 0, 0);
    nx(); drv(0, 0, 0, 0);
    nx(); chk("R3", "n3 own", int'(own_vld), 5'b00110);
    ph("R3", 2, 7); ph("R2", 1, 0);
    nx(); chk("R3", "n4 own", int'(own_vld), 5'b01100);
    nx(); chk("R6", "n5 own", int'(own_vld), 5'b11000);
    ph("R6", 4, 7); ph("R6", 3, 0);
    nx(); chk("R6", "waiting frees response", int'(own_vld), 5'b10000);
    chk("R6", "busy n6", int'(data_busy), 1);
    nx(); nx(); ph("R6", 4, 7); chk("R6", "busy n8", int'(data_busy), 1);
    nx(); ph("R6", 4, 0);
    chk("R8", "done 7", int'(done_vld), 1); chk("R8", "tag 7", int'(done_tag), 7);
    nx(); chk("R2", "wrapped tag retires", int'(done_tag), 0);
    chk("R8", "done 0", int'(done_vld), 1);
    chk("R6", "busy drops", int'(data_busy), 0);
    chk("R6", "idle", int'(own_vld), 0);
    nx();
  endtask

  task automatic t_abort();
    nx(); drv(1, 0, 0, 1);
    nx(); drv(0, 0, 0, 0);
    repeat (5) nx();
    chk("R10", "idle error ignored done", int'(done_vld), 1);
    chk("R10", "idle error ignored tag", int'(done_tag), 1);
    chk("R10", "idle error ignored err", int'(done_err), 0);
    nx();
    nx(); drv(1, 0, 0, 0);
    nx();
    nx(); drv(0, 0, 0, 1);
    ph("R9", 1, 2);
    nx(); drv(0, 0, 0, 0);
    chk("R9", "aborted skips snoop", int'(own_vld), 5'b00010); ph("R9", 1, 3);
    nx(); chk("R9", "aborted skips response", int'(own_vld), 5'b00100); ph("R9", 2, 3);
    nx(); chk("R9", "abort done", int'(done_vld), 1);
    chk("R9", "abort tag", int'(done_tag), 2);
    chk("R9", "abort flag", int'(done_err), 1);
    chk("R9", "follower rsp", int'(own_vld), 5'b01000);
    nx(); chk("R9", "follower dat", int'(own_vld), 5'b10000); ph("R9", 4, 3);
    nx(); chk("R9", "follower done", int'(done_vld), 1);
    chk("R9", "follower tag", int'(done_tag), 3);
    chk("R9", "follower ok", int'(done_err), 0);
    nx();
  endtask

  task automatic t_full();
    int ndone;
    int exp_tag;
    nx(); drv(1, 0, 3, 0);
    repeat (7) nx();
    chk("R1", "ready with seven", int'(req_ready), 1);
    nx();
    chk("R1", "ready low at eight", int'(req_ready), 0);
    chk("R2", "tag wrapped", int'(req_tag), 4);
    nx(); drv(0, 0, 0, 0);
    chk("R1", "ready back", int'(req_ready), 1);
    chk("R1", "refused takes no tag", int'(req_tag), 4);
    ndone = 0;
    exp_tag = 4;
    for (int i = 0; i < 60; i++) begin
      if (done_vld) begin
        chk("R8", "full order", int'(done_tag), exp_tag);
        exp_tag = (exp_tag + 1) % 8;
        ndone++;
      end
      nx();
    end
    chk("R1", "retired count", ndone, 8);
  endtask

  initial begin
    t_reset();
    t_single();
    t_pipe();
    t_rsp_stall();
    t_dat_stall();
    t_abort();
    t_full();
    report();
    $finish;
  end
endmodule